// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Edge Interrupts

This block is a 32-pin general-purpose I/O port on a word-wide register bus. Software sets each pin to input or output with the direction register. Each output can drive both levels or act as an open-drain line that only pulls low. The data register holds the levels the outputs drive. When read, it returns the written value for output pins and the synchronized pad level for input pins.

Every pin passes through a two-flop synchronizer. An edge detector follows the synchronizer. Selected edges set sticky bits in an event register. Software clears these bits by writing ones to them. A mask register picks which events drive the single interrupt line.

The parameter `DUAL_SENSE` selects how edge selection is set up. With `DUAL_SENSE = 0`, there is one sense bit per pin. With `DUAL_SENSE = 1`, there is a two-bit field per pin, and the fields are spread across two registers. In every per-pin register, pin n sits at bit 31−n. The pad vectors are indexed by pin number.

Top module: `gpio_edge_port`

## Requirements
- R1: Registers sit at byte offsets 0x00 direction, 0x04 open-drain select, 0x08 data, 0x0C event, 0x10 mask, 0x14 sense A and 0x18 sense B. All registers reset to 0. Reads of any other offset return 0. An access with `bus_addr[1:0]` nonzero writes nothing and reads 0.
- R2: Pin n maps to bit 31−n of every register, and to bit n of `pad_in`, `pad_out` and `pad_oe`.
- R3: A direction bit of 1 makes the pin an output, and 0 makes it an input. An input pin has `pad_oe` 0 and `pad_out` 0. A push-pull output has `pad_oe` 1 and `pad_out` equal to its data bit.
- R4: An open-drain output (open-drain select bit 1) with data 0 gives `pad_oe` 1 and `pad_out` 0. With data 1 it gives `pad_oe` 0 and `pad_out` 0.
- R5: Reading the data register returns the written data bit for output pins and the synchronized pad level for input pins. A pad change shows in the read value after two rising clock edges, not after one.
- R6: A selected pad edge sets its event bit on the third rising clock edge after the pad changes. The bit then stays set until software clears it.
- R7: Writing the event register clears each bit written as 1 and leaves the others unchanged. If a new edge is latched in the same cycle as a clear of that bit, the bit stays set.
- R8: `irq` is 1 exactly while some event bit and its mask bit are both 1. A mask of 0 keeps `irq` low but does not hide the event bit from reads.
- R9: With `DUAL_SENSE = 0`, a sense A bit of 1 latches only falling edges, and 0 latches both edges. Sense B reads 0 and ignores writes.
- R10: With `DUAL_SENSE = 1`, pins 0–15 take their field from sense A and pins 16–31 from sense B. The field for pin n is at bits [2k+1:2k] with k = 15 − (n mod 16). Field value 2 latches falling edges, 1 latches rising edges, and 0 latches both.
- R11: With `DUAL_SENSE = 1`, field value 3 latches no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pad_in | input | 32 | Pad levels, bit n is pin n |
| pad_out | output | 32 | Driven level, bit n is pin n |
| pad_oe | output | 32 | Output enable, bit n is pin n |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets the reversed bit order with single-pin patterns. A design that indexes pads directly would drive pin 31 when pin 0 was written.

It times a pad edge through the synchronizer to the exact cycle it is latched. A design with one flop too few or too many would show the event a cycle early or late.

It lands a clear on the same edge as a new event. A design that gives the clear priority would lose that event.

It walks falling-only, rising-only, both-edge and reserved sense settings on pins in both halves of the two-bit layout. A design with swapped field positions would latch the wrong edge or the wrong pin.

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter int NPIN = 32,
  parameter int AW = 5,
  parameter bit DUAL_SENSE = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic            irq
);
  localparam int SW = AW - 2;
  localparam int HALF = NPIN / 2;
  localparam logic [SW-1:0] A_DIR = SW'(0);
  localparam logic [SW-1:0] A_ODS = SW'(1);
  localparam logic [SW-1:0] A_DAT = SW'(2);
  localparam logic [SW-1:0] A_EVT = SW'(3);
  localparam logic [SW-1:0] A_MSK = SW'(4);
  localparam logic [SW-1:0] A_SNA = SW'(5);
  localparam logic [SW-1:0] A_SNB = SW'(6);

  logic [NPIN-1:0] dir_q, ods_q, dat_q, evt_q, msk_q, sna_q, snb_q;
  logic [NPIN-1:0] s1_q, s2_q, s3_q;
  logic [NPIN-1:0] pin_r, drv_out, drv_oe, rise, fall, hit, wclr;

  wire          aligned = (bus_addr[1:0] == 2'b00);
  wire [SW-1:0] sel     = bus_addr[AW-1:2];
  wire          wr_ok   = bus_wr && aligned;

  genvar n;
  generate
    for (n = 0; n < NPIN; n++) begin : g_pad
      assign pin_r[NPIN-1-n] = pad_in[n];
      assign pad_out[n]      = drv_out[NPIN-1-n];
      assign pad_oe[n]       = drv_oe[NPIN-1-n];
    end
  endgenerate

  assign drv_out = dir_q & ~ods_q & dat_q;
  assign drv_oe  = dir_q & (~ods_q | ~dat_q);

  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;

  genvar b;
  generate
    if (DUAL_SENSE) begin : g_dual
      for (b = 0; b < NPIN; b++) begin : g_bit
        logic [1:0] fld;
        if (b >= HALF) begin : g_hi
          assign fld = sna_q[2*(b-HALF) +: 2];
        end else begin : g_lo
          assign fld = snb_q[2*b +: 2];
        end
        assign hit[b] = ((fld == 2'd0) & (rise[b] | fall[b])) |
                        ((fld == 2'd1) & rise[b]) |
                        ((fld == 2'd2) & fall[b]);
      end
    end else begin : g_single
      assign hit = fall | (rise & ~sna_q);
    end
  endgenerate

  assign wclr = (wr_ok && sel == A_EVT) ? bus_wdata : '0;
  assign irq  = |(evt_q & msk_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      ods_q <= '0;
      dat_q <= '0;
      evt_q <= '0;
      msk_q <= '0;
      sna_q <= '0;
      snb_q <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
      s3_q  <= '0;
    end else begin
      if (wr_ok && sel == A_DIR) dir_q <= bus_wdata;
      if (wr_ok && sel == A_ODS) ods_q <= bus_wdata;
      if (wr_ok && sel == A_DAT) dat_q <= bus_wdata;
      if (wr_ok && sel == A_MSK) msk_q <= bus_wdata;
      if (wr_ok && sel == A_SNA) sna_q <= bus_wdata;
      if (wr_ok && sel == A_SNB && DUAL_SENSE) snb_q <= bus_wdata;
      s1_q  <= pin_r;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      evt_q <= (evt_q & ~wclr) | hit;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (sel)
        A_DIR:   bus_rdata = dir_q;
        A_ODS:   bus_rdata = ods_q;
        A_DAT:   bus_rdata = (dir_q & dat_q) | (~dir_q & s2_q);
        A_EVT:   bus_rdata = evt_q;
        A_MSK:   bus_rdata = msk_q;
        A_SNA:   bus_rdata = sna_q;
        A_SNB:   bus_rdata = snb_q;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk #(
  parameter int NPIN = 32,
  parameter int AW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [NPIN-1:0] bus_wdata,
  input logic            irq,
  input logic [NPIN-1:0] evt_q,
  input logic [NPIN-1:0] msk_q,
  input logic [NPIN-1:0] s2_q,
  input logic [NPIN-1:0] s3_q
);
  logic evt_wr;
  assign evt_wr = bus_wr && (bus_addr == AW'(12));

  a_r6_event_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_wr |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  a_r6_set_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(s2_q ^ s3_q)) == '0));

  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wr |=> ((evt_q & $past(bus_wdata) & ~$past(s2_q ^ s3_q)) == '0));

  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '0) |-> !irq);

  a_r8_irq_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt_q != '0));
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .evt_q(evt_q), .msk_q(msk_q),
  .s2_q(s2_q), .s3_q(s3_q)
);

// File: tb/gpio_edge_port_bench.sv
`timescale 1ns/1ps
module gpio_edge_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] pad_in = '0;
  logic [31:0] rd_s, rd_d, out_s, oe_s, out_d, oe_d;
  logic irq_s, irq_d;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  gpio_edge_port #(.DUAL_SENSE(1'b0)) u_gpio_edge_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_s), .pad_in(pad_in),
    .pad_out(out_s), .pad_oe(oe_s), .irq(irq_s));

  gpio_edge_port #(.DUAL_SENSE(1'b1)) u_gpio_edge_port_dual (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_d), .pad_in(pad_in),
    .pad_out(out_d), .pad_oe(oe_d), .irq(irq_d));

  typedef struct packed {
    logic [31:0] dir, od, dat, eo, eoe, erd;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{32'hFFFF0000, 32'h0, 32'hA5A50000, 32'h0000A5A5, 32'h0000FFFF, 32'hA5A50000},
    '{32'h80000000, 32'h0, 32'h80000000, 32'h00000001, 32'h00000001, 32'h80000000},
    '{32'hC0000000, 32'hC0000000, 32'h80000000, 32'h0, 32'h00000002, 32'h80000000},
    '{32'h0000000F, 32'h00000003, 32'h0000000A, 32'h10000000, 32'hB0000000, 32'h0000000A},
    '{32'h0, 32'h0, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bw(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a);
    bus_addr = a;
    #1;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", n_chk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state and unmapped reads
    for (int a = 0; a < 8; a++) begin
      rd(5'(a * 4));
      check("R1 reset read", rd_s, 32'h0);
    end
    check("R1 reset irq", {31'h0, irq_s}, 32'h0);
    check("R3 reset oe", oe_s, 32'h0);
    bw(5'h01, 32'hFFFFFFFF);
    rd(5'h00);
    check("R1 misaligned write ignored", rd_s, 32'h0);
    rd(5'h01);
    check("R1 misaligned read", rd_s, 32'h0);

    // R2 R3 R4 R5 vector table
    for (int i = 0; i < 5; i++) begin
      bw(5'h00, VEC[i].dir);
      bw(5'h04, VEC[i].od);
      bw(5'h08, VEC[i].dat);
      check("R2 R3 R4 pad_out", out_s, VEC[i].eo);
      check("R2 R3 R4 pad_oe", oe_s, VEC[i].eoe);
      rd(5'h08);
      check("R5 data readback", rd_s, VEC[i].erd);
    end
    bw(5'h08, 32'h0);

    // R5 synchronizer depth on input read
    @(negedge clk);
    pad_in = 32'h00000001;
    tick(1);
    rd(5'h08);
    check("R5 one edge not visible", rd_s, 32'h0);
    tick(1);
    rd(5'h08);
    check("R5 pin0 at msb", rd_s, 32'h80000000);
    tick(3);
    bw(5'h0C, 32'hFFFFFFFF);
    rd(5'h0C);
    check("R7 all ones clears", rd_s, 32'h0);
    check("R7 all ones clears dual", rd_d, 32'h0);

    // R6 latch timing, R8 irq
    bw(5'h10, 32'hFFFFFFFF);
    @(negedge clk);
    pad_in[5] = 1'b1;
    tick(2);
    rd(5'h0C);
    check("R6 not yet latched", rd_s, 32'h0);
    check("R8 irq low before event", {31'h0, irq_s}, 32'h0);
    tick(1);
    rd(5'h0C);
    check("R6 rise latched third edge", rd_s, 32'h04000000);
    check("R8 irq high", {31'h0, irq_s}, 32'h1);
    tick(5);
    rd(5'h0C);
    check("R6 sticky", rd_s, 32'h04000000);
    bw(5'h0C, 32'h04000000);
    rd(5'h0C);
    check("R7 one-hot clear", rd_s, 32'h0);
    check("R8 irq drops", {31'h0, irq_s}, 32'h0);
    pad_in[5] = 1'b0;
    tick(4);
    rd(5'h0C);
    check("R9 both edges fall", rd_s, 32'h04000000);
    bw(5'h0C, 32'hFFFFFFFF);

    // R9 falling only
    bw(5'h14, 32'h04000000);
    pad_in[5] = 1'b1;
    tick(4);
    rd(5'h0C);
    check("R9 rise ignored", rd_s, 32'h0);
    pad_in[5] = 1'b0;
    tick(4);
    rd(5'h0C);
    check("R9 fall latched", rd_s, 32'h04000000);
    bw(5'h0C, 32'hFFFFFFFF);

    // R7 selective clear
    pad_in[2] = 1'b1; pad_in[3] = 1'b1;
    tick(4);
    rd(5'h0C);
    check("R6 two events", rd_s, 32'h30000000);
    bw(5'h0C, 32'h10000000);
    rd(5'h0C);
    check("R7 other kept", rd_s, 32'h20000000);
    bw(5'h0C, 32'hFFFFFFFF);

    // R7 set wins over same-cycle clear
    @(negedge clk);
    pad_in[2] = 1'b0;
    tick(2);
    bus_addr = 5'h0C; bus_wdata = 32'h20000000; bus_wr = 1'b1;
    tick(1);
    bus_wr = 1'b0;
    rd(5'h0C);
    check("R7 new edge wins", rd_s, 32'h20000000);

    // R8 mask
    bw(5'h10, 32'h0);
    rd(5'h0C);
    check("R8 masked irq", {31'h0, irq_s}, 32'h0);
    check("R8 event still visible", rd_s, 32'h20000000);
    bw(5'h10, 32'h20000000);
    check("R8 own mask bit", {31'h0, irq_s}, 32'h1);
    bw(5'h10, 32'hDFFFFFFF);
    check("R8 other mask bits", {31'h0, irq_s}, 32'h0);
    bw(5'h0C, 32'hFFFFFFFF);

    // R9 sense B absent in single mode
    bw(5'h18, 32'h80000003);
    rd(5'h18);
    check("R9 sense B reads 0", rd_s, 32'h0);
    check("R10 dual sense B writable", rd_d, 32'h80000003);

    // R10 R11 two-bit fields (dual instance)
    bw(5'h14, 32'h01000000);
    bw(5'h0C, 32'hFFFFFFFF);
    pad_in[3] = 1'b0;
    tick(4);
    rd(5'h0C);
    check("R10 rise-only ignores fall", rd_d, 32'h0);
    pad_in[3] = 1'b1;
    tick(4);
    rd(5'h0C);
    check("R10 rise-only latches rise", rd_d, 32'h10000000);
    bw(5'h0C, 32'hFFFFFFFF);
    pad_in[16] = 1'b1;
    tick(4);
    rd(5'h0C);
    check("R10 fall-only ignores rise", rd_d, 32'h0);
    pad_in[16] = 1'b0;
    tick(4);
    rd(5'h0C);
    check("R10 fall-only pin16", rd_d, 32'h00008000);
    bw(5'h0C, 32'hFFFFFFFF);
    pad_in[20] = 1'b1;
    tick(4);
    rd(5'h0C);
    check("R10 both-edge field", rd_d, 32'h00000800);
    bw(5'h0C, 32'hFFFFFFFF);
    pad_in[31] = 1'b1;
    tick(4);
    pad_in[31] = 1'b0;
    tick(4);
    rd(5'h0C);
    check("R11 reserved field", rd_d, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule